// File: doc/BRIEF.md
# Adaptive Contrast Gain with Clip Feedback

This block scales a 24-bit RGB pixel stream by a common gain between 1.0 and 2.0. Each 8-bit channel is multiplied by the gain and clamped to full scale. The block also counts, over each frame, the pixels in which at least one channel clips. At every end-of-frame pulse it uses that count to adjust the gain for the next frame.

The host sets two plain parallel inputs. The first is a desired contrast gain and the second is a clipping tolerance. While clipping stays within the tolerance, the gain climbs one step per frame toward the desired value. When clipping exceeds the tolerance, the gain falls back one step at a time. The gain never changes inside a frame.

Pixel lanes are packed as red in bits 23:16, green in bits 15:8 and blue in bits 7:0. All three lanes are treated alike.

Top module: `contrast_gain_ctrl`

## Requirements
- R1: After reset the gain output is 128 (1.0 in the 1.7 format: one integer bit and seven fraction bits, with a ninth bit so that 256 means 2.0), and the output valid flag is 0.
- R2: Each output lane equals min(floor(lane × gain / 128), 255). It appears one clock after the input pixel is taken, and the input valid flag is forwarded with the same one-clock delay.
- R3: The gain output changes only on the clock edge that samples the end-of-frame pulse.
- R4: A valid pixel counts as clipped when the scaled result of any lane is 255 or more. The per-frame clip count saturates at its maximum and is cleared at each end-of-frame pulse, so each frame starts from zero.
- R5: At end of frame, if the clip count (including a pixel taken in that same cycle) is greater than the tolerance, the gain drops by 1. It never drops below 128.
- R6: At end of frame, if the count is within the tolerance and the gain is below the effective target, the gain rises by 1.
- R7: At end of frame, if the effective target is below the gain, the gain is set straight to the target. This takes precedence over the one-step decrease.
- R8: The effective target is the host value clamped to the range 128 to 256.
- R9: Cycles with the input valid flag low are never counted as clipped, whatever their data.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pix_valid_i | input | 1 | Input pixel valid |
| pix_data_i | input | 24 | Input pixel, R[23:16] G[15:8] B[7:0] |
| frame_end_i | input | 1 | One-cycle end-of-frame pulse |
| user_gain_i | input | GF+2 (9) | Desired gain, 1.7 format |
| ovf_limit_i | input | CNT_W (16) | Clipped-pixel tolerance per frame |
| pix_valid_o | output | 1 | Output pixel valid |
| pix_data_o | output | 24 | Scaled, clamped pixel |
| gain_o | output | GF+2 (9) | Gain currently applied |

## Verification
Scaling is tried at gains of 1.0, 130/128 and 2.0. This separates pass-through, correct floor rounding and clamping.

Pixels of 251 and 252 at gain 130 sit just under and just on the clip threshold. This separates a threshold of "reaches 255" from an off-by-one comparison.

Bursts of clipped pixels tell apart strict and non-strict comparison with the tolerance, clearing of the count between frames, and saturation versus wrap of a narrowed counter. Invalid cycles carrying full-scale data show that the valid flag qualifies the count.

Target changes above the maximum, below the gain and below 1.0 exercise the clamping and the direct drop to the target.

// File: rtl/contrast_gain_ctrl.sv
module contrast_gain_ctrl #(
  parameter int CW    = 8,
  parameter int GF    = 7,
  parameter int CNT_W = 16,
  localparam int GW   = GF + 2,
  localparam int NCH  = 3,
  localparam int DW   = NCH * CW
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pix_valid_i,
  input  logic [DW-1:0]    pix_data_i,
  input  logic             frame_end_i,
  input  logic [GW-1:0]    user_gain_i,
  input  logic [CNT_W-1:0] ovf_limit_i,
  output logic             pix_valid_o,
  output logic [DW-1:0]    pix_data_o,
  output logic [GW-1:0]    gain_o
);

  localparam int          PW      = CW + GW;
  localparam logic [GW-1:0] G_ONE = GW'(1) << GF;
  localparam logic [GW-1:0] G_TWO = GW'(2) << GF;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [PW-GF-1:0] FULL = (PW-GF)'((1 << CW) - 1);

  logic [GW-1:0]    gain_q;
  logic [CNT_W-1:0] cnt_q;
  logic [NCH-1:0]   lane_clip;
  logic [DW-1:0]    scaled;

  for (genvar c = 0; c < NCH; c++) begin : g_lane
    logic [PW-1:0]    prod;
    logic [PW-GF-1:0] shf;
    assign prod = PW'(pix_data_i[c*CW +: CW]) * PW'(gain_q);
    assign shf  = prod[PW-1:GF];
    assign lane_clip[c] = shf >= FULL;
    assign scaled[c*CW +: CW] = lane_clip[c] ? {CW{1'b1}} : shf[CW-1:0];
  end

  wire              pix_clip  = pix_valid_i && |lane_clip;
  wire [CNT_W-1:0]  cnt_total = (cnt_q == CNT_MAX) ? CNT_MAX : cnt_q + CNT_W'(pix_clip);
  wire              too_many  = cnt_total > ovf_limit_i;
  wire [GW-1:0]     target    = (user_gain_i < G_ONE) ? G_ONE :
                                (user_gain_i > G_TWO) ? G_TWO : user_gain_i;

  logic [GW-1:0] gain_next;
  always_comb begin
    gain_next = gain_q;
    if (gain_q > target)       gain_next = target;
    else if (too_many)         gain_next = (gain_q > G_ONE) ? gain_q - 1'b1 : G_ONE;
    else if (gain_q < target)  gain_next = gain_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gain_q      <= G_ONE;
      cnt_q       <= '0;
      pix_valid_o <= 1'b0;
      pix_data_o  <= '0;
    end else begin
      pix_valid_o <= pix_valid_i;
      pix_data_o  <= scaled;
      if (frame_end_i) begin
        gain_q <= gain_next;
        cnt_q  <= '0;
      end else begin
        cnt_q  <= cnt_total;
      end
    end
  end

  assign gain_o = gain_q;

  assert_gain_only_at_frame_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_end_i |=> $stable(gain_q));

  assert_gain_bounds_R8: assert property (@(posedge clk) disable iff (!rst_n)
    gain_q >= G_ONE && gain_q <= G_TWO);

  assert_count_saturates_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == CNT_MAX && !frame_end_i) |=> cnt_q == CNT_MAX);

  assert_count_cleared_R4: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end_i |=> cnt_q == '0);

  assert_valid_forward_R2: assert property (@(posedge clk) disable iff (!rst_n)
    pix_valid_i |=> pix_valid_o);

  assert_rise_single_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end_i |=> gain_q <= $past(gain_q) + 1'b1);

  assert_invalid_not_counted_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!pix_valid_i && !frame_end_i) |=> $stable(cnt_q));

endmodule

// File: tb/tb_contrast_gain_ctrl.sv
module tb_contrast_gain_ctrl;
  localparam int CNT_W = 4;

  logic        clk = 0;
  logic        rst_n = 0;
  logic        pix_valid_i = 0;
  logic [23:0] pix_data_i = '0;
  logic        frame_end_i = 0;
  logic [8:0]  user_gain_i = 9'd128;
  logic [CNT_W-1:0] ovf_limit_i = 4'd15;
  logic        pix_valid_o;
  logic [23:0] pix_data_o;
  logic [8:0]  gain_o;

  int checks = 0;
  int fails  = 0;

  contrast_gain_ctrl #(.CNT_W(CNT_W)) dut (
    .clk(clk), .rst_n(rst_n), .pix_valid_i(pix_valid_i), .pix_data_i(pix_data_i),
    .frame_end_i(frame_end_i), .user_gain_i(user_gain_i), .ovf_limit_i(ovf_limit_i),
    .pix_valid_o(pix_valid_o), .pix_data_o(pix_data_o), .gain_o(gain_o));

  always #5 clk = ~clk;

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic pix(logic [23:0] d);
    @(negedge clk); pix_valid_i = 1; pix_data_i = d;
    @(negedge clk); pix_valid_i = 0;
  endtask

  task automatic frame();
    @(negedge clk); frame_end_i = 1;
    @(negedge clk); frame_end_i = 0;
  endtask

  task automatic t_reset();
    check("R1 gain", gain_o, 128);
    check("R1 valid", pix_valid_o, 0);
  endtask

  task automatic t_passthrough();
    pix(24'h1280FF);
    check("R2 unity data", pix_data_o, 24'h1280FF);
    check("R2 valid fwd", pix_valid_o, 1);
    @(negedge clk);
    check("R2 valid drop", pix_valid_o, 0);
  endtask

  task automatic t_ramp();
    user_gain_i = 9'd130;
    frame(); check("R6 step1", gain_o, 129);
    frame(); check("R6 step2", gain_o, 130);
    frame(); check("R6 hold at target", gain_o, 130);
  endtask

  task automatic t_scale();
    pix({8'd100, 8'd200, 8'd255});
    check("R2 scaled 130", pix_data_o, {8'd101, 8'd203, 8'd255});
    repeat (3) @(negedge clk);
    check("R3 no change mid-frame", gain_o, 130);
    frame(); check("R5 within limit", gain_o, 130);
  endtask

  task automatic t_threshold();
    ovf_limit_i = 0;
    pix({8'd251, 8'd0, 8'd0});
    check("R2 below clip", pix_data_o, {8'd254, 16'd0});
    frame(); check("R4 251 not clipped", gain_o, 130);
    pix({8'd0, 8'd252, 8'd0});
    check("R2 at clip", pix_data_o, {8'd0, 8'd255, 8'd0});
    frame(); check("R4 252 clipped", gain_o, 129);
  endtask

  task automatic t_invalid();
    ovf_limit_i = 1;
    pix(24'h0000FF);
    @(negedge clk); pix_data_i = 24'hFFFFFF;
    repeat (5) @(negedge clk);
    frame(); check("R9 invalid not counted", gain_o, 130);
    pix(24'hFF0000); pix(24'hFF0000);
    frame(); check("R5 over limit", gain_o, 129);
    pix(24'hFF0000);
    frame(); check("R4 count cleared", gain_o, 130);
  endtask

  task automatic t_follow_down();
    user_gain_i = 9'd128;
    ovf_limit_i = 0;
    pix(24'hFF0000);
    frame(); check("R7 jump to target", gain_o, 128);
    pix(24'hFF0000);
    frame(); check("R5 floor", gain_o, 128);
  endtask

  task automatic t_clamp_high();
    user_gain_i = 9'd300;
    ovf_limit_i = 15;
    for (int i = 0; i < 130; i++) frame();
    check("R8 max 2.0", gain_o, 256);
    pix({8'd100, 8'd128, 8'd0});
    check("R2 scaled 2.0", pix_data_o, {8'd200, 8'd255, 8'd0});
    frame(); check("R8 clamp stay", gain_o, 256);
  endtask

  task automatic t_saturate();
    ovf_limit_i = 14;
    for (int i = 0; i < 20; i++) pix(24'hFF0000);
    frame(); check("R4 saturating count", gain_o, 255);
    user_gain_i = 9'd50;
    frame(); check("R8 low clamp", gain_o, 128);
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_passthrough();
    t_ramp();
    t_scale();
    t_threshold();
    t_invalid();
    t_follow_down();
    t_clamp_high();
    t_saturate();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule